// File: doc/BRIEF.md
# Four-phase request/wait memory handshake unit

This unit connects a synchronous processor core to a memory that runs without a shared clock. The core issues one read or write command at a time. The unit registers the address, the direction and, for a write, the data. It then runs a four-phase exchange with the memory. The unit raises its request. The memory answers by dropping its wait line. The unit withdraws the request, and the memory raises wait again. After that last step the core receives a one-cycle completion pulse.

The wait line idles high. A falling edge on it means one of two things: read data is valid on the memory data bus, or the memory has taken the write data. The unit starts a new request only while the synchronized wait line is high. Wait reaches the state machine through a chain of synchronizer flip-flops, and the length of that chain is a parameter. A single buffer register serves both directions. It supplies the write data to the memory and receives the read data. The core reads the most recent transferred word from it.

Top module: `mem_handshake_unit`

## Requirements
- R1: After reset, mem_req is 0, done is 0, rdata is 0 and mem_rnw is 1. With mem_wait held high, cmd_ready is 1 once the synchronizer has settled.
- R2: A command is taken only on a cycle where cmd_valid is 1 and cmd_ready is 1. cmd_ready is 1 only when the unit is idle and the synchronized mem_wait is high. While mem_wait is held low, an offered command raises no request.
- R3: When a command is taken, mem_req rises and mem_addr, mem_rnw and mem_wdata take the command values. These outputs stay stable as long as mem_req is 1, even if the command inputs change.
- R4: While mem_wait stays high, mem_req stays 1. After mem_wait falls, mem_req drops within SYNC_STAGES+2 clock cycles.
- R5: On a read, the word present on mem_rdata when mem_wait falls is captured into the buffer register. After done it appears on rdata.
- R6: On a write, mem_wdata carries the command write data from the rise of the request until the memory drops mem_wait. After done, rdata shows the written word.
- R7: done is a single-cycle pulse. It comes only after mem_req has dropped and mem_wait has been reasserted. After it, the unit is idle again.
- R8: Commands offered while a transfer is in progress are ignored. A command held through a transfer and withdrawn on the done cycle raises no second request.
- R9: mem_rnw encodes the direction: 1 means read and 0 means write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cmd_valid | input | 1 | Core offers a command |
| cmd_write | input | 1 | 1 means write, 0 means read |
| cmd_addr | input | ADDR_W | Command address |
| cmd_wdata | input | DATA_W | Command write data |
| cmd_ready | output | 1 | Unit can take a command this cycle |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | DATA_W | Buffer register contents |
| mem_req | output | 1 | Request to memory |
| mem_rnw | output | 1 | Direction to memory, 1 means read |
| mem_addr | output | ADDR_W | Address to memory |
| mem_wdata | output | DATA_W | Write data to memory |
| mem_wait | input | 1 | Asynchronous wait from memory, idles high |
| mem_rdata | input | DATA_W | Read data from memory |

## Verification
The hardest condition to reach from the ports is a command offered while the memory still holds wait low. This is the one case where the unit must refuse to start even though it is idle. The bench drives mem_wait low before it raises cmd_valid. It then holds the command for many cycles and watches mem_req, and only afterwards releases wait. A second hard case is a command that stays asserted, with changing contents, through a whole transfer. The bench keeps cmd_valid high and scrambles the command inputs after acceptance. This exposes any output that follows the inputs and any second request raised too early.

// File: rtl/mhs_pkg.sv
package mhs_pkg;
   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ASSERT  = 2'd1,
      ST_RELEASE = 2'd2,
      ST_FINISH  = 2'd3
   } mhs_state_t;
endpackage

// File: rtl/mhs_sync.sv
module mhs_sync #(
   parameter int   STAGES  = 2,
   parameter logic RST_VAL = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic async_in,
   output logic sync_out
);
   if (STAGES < 2) begin : g_bad_depth
      $error("mhs_sync: STAGES must be at least 2");
   end

   logic [STAGES-1:0] chain;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], async_in};
   end

   assign sync_out = chain[STAGES-1];
endmodule

// File: rtl/mhs_fsm.sv
module mhs_fsm
   import mhs_pkg::*;
(
   input  logic clk,
   input  logic rst_n,
   input  logic cmd_valid,
   input  logic wait_s,
   output logic cmd_ready,
   output logic accept,
   output logic capture,
   output logic req,
   output logic done
);
   mhs_state_t state, state_nx;
   logic req_q;

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE:    if (cmd_valid && wait_s) state_nx = ST_ASSERT;
         ST_ASSERT:  if (!wait_s)             state_nx = ST_RELEASE;
         ST_RELEASE: if (wait_s)              state_nx = ST_FINISH;
         default:                             state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         req_q <= 1'b0;
      end else begin
         state <= state_nx;
         if (accept)       req_q <= 1'b1;
         else if (capture) req_q <= 1'b0;
      end
   end

   assign cmd_ready = (state == ST_IDLE) && wait_s;
   assign accept    = cmd_ready && cmd_valid;
   assign capture   = (state == ST_ASSERT) && !wait_s;
   assign req       = req_q;
   assign done      = (state == ST_FINISH);
endmodule

// File: rtl/mhs_buffer.sv
module mhs_buffer #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              accept,
   input  logic              capture,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic [ADDR_W-1:0] addr_q,
   output logic              rnw_q,
   output logic [DATA_W-1:0] mbr_q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_q <= '0;
         rnw_q  <= 1'b1;
         mbr_q  <= '0;
      end else begin
         if (accept) begin
            addr_q <= cmd_addr;
            rnw_q  <= !cmd_write;
            if (cmd_write) mbr_q <= cmd_wdata;
         end else if (capture && rnw_q) begin
            mbr_q <= mem_rdata;
         end
      end
   end
endmodule

// File: rtl/mem_handshake_unit.sv
module mem_handshake_unit #(
   parameter int ADDR_W      = 12,
   parameter int DATA_W      = 16,
   parameter int SYNC_STAGES = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_valid,
   input  logic              cmd_write,
   input  logic [ADDR_W-1:0] cmd_addr,
   input  logic [DATA_W-1:0] cmd_wdata,
   output logic              cmd_ready,
   output logic              done,
   output logic [DATA_W-1:0] rdata,
   output logic              mem_req,
   output logic              mem_rnw,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_wait,
   input  logic [DATA_W-1:0] mem_rdata
);
   if (ADDR_W < 1 || DATA_W < 1) begin : g_bad_width
      $error("mem_handshake_unit: widths must be positive");
   end

   logic wait_s;
   logic accept;
   logic capture;
   logic [DATA_W-1:0] mbr;

   mhs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sync (
      .clk(clk), .rst_n(rst_n), .async_in(mem_wait), .sync_out(wait_s)
   );

   mhs_fsm u_fsm (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .wait_s(wait_s),
      .cmd_ready(cmd_ready), .accept(accept), .capture(capture),
      .req(mem_req), .done(done)
   );

   mhs_buffer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_buf (
      .clk(clk), .rst_n(rst_n), .accept(accept), .capture(capture),
      .cmd_write(cmd_write), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
      .mem_rdata(mem_rdata), .addr_q(mem_addr), .rnw_q(mem_rnw), .mbr_q(mbr)
   );

   assign mem_wdata = mbr;
   assign rdata     = mbr;
endmodule

// File: rtl/mhs_checker.sv
module mhs_checker #(
   parameter int ADDR_W = 12,
   parameter int DATA_W = 16
) (
   input logic              clk,
   input logic              rst_n,
   input logic              mem_req,
   input logic              mem_rnw,
   input logic [ADDR_W-1:0] mem_addr,
   input logic [DATA_W-1:0] mem_wdata,
   input logic              done,
   input logic              wait_s
);
   assert_stable_out_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && $past(mem_req)) |->
         ($stable(mem_addr) && $stable(mem_rnw) && $stable(mem_wdata)));

   assert_req_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && wait_s) |=> mem_req);

   assert_start_on_wait_R2: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(mem_req) |-> $past(wait_s));

   assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);

   assert_done_after_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (!mem_req && wait_s));
endmodule

bind mem_handshake_unit mhs_checker #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .mem_req(mem_req), .mem_rnw(mem_rnw),
   .mem_addr(mem_addr), .mem_wdata(mem_wdata), .done(done), .wait_s(wait_s)
);

// File: tb/mem_handshake_unit_tb.sv
module mem_handshake_unit_tb;
   localparam int AW = 12;
   localparam int DW = 16;
   localparam int SS = 2;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cmd_valid = 1'b0;
   logic cmd_write = 1'b0;
   logic [AW-1:0] cmd_addr = '0;
   logic [DW-1:0] cmd_wdata = '0;
   logic cmd_ready, done, mem_req, mem_rnw;
   logic [DW-1:0] rdata, mem_wdata;
   logic [AW-1:0] mem_addr;
   logic mem_wait = 1'b1;
   logic [DW-1:0] mem_rdata = '0;

   int checks = 0;
   int errors = 0;
   logic [DW-1:0] mem_arr [16];

   always #4 clk = ~clk;

   mem_handshake_unit #(.ADDR_W(AW), .DATA_W(DW), .SYNC_STAGES(SS)) u_dut (
      .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_write(cmd_write),
      .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_ready(cmd_ready),
      .done(done), .rdata(rdata), .mem_req(mem_req), .mem_rnw(mem_rnw),
      .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_wait(mem_wait),
      .mem_rdata(mem_rdata)
   );

   task automatic check(input bit ok, input string req, input logic [31:0] act,
                        input logic [31:0] exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   task automatic finish_sim();
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      check(1'b0, "watchdog", 32'd0, 32'd1);
      finish_sim();
   end

   // Memory side of one transfer plus the core-side completion checks.
   task automatic responder(input bit is_wr, input logic [AW-1:0] ea,
                            input logic [DW-1:0] ewd, input int lat_fall,
                            input int lat_rise);
      logic [AW-1:0] a;
      logic rnw;
      logic [DW-1:0] wd;
      int n;
      int dn;
      n = 0;
      while (!mem_req && n < 200) begin @(negedge clk); n++; end
      check(mem_req, "R2 request raised", {31'd0, mem_req}, 32'd1);
      a = mem_addr; rnw = mem_rnw; wd = mem_wdata;
      check(a == ea, "R3 address", {20'd0, a}, {20'd0, ea});
      check(rnw == !is_wr, "R9 direction", {31'd0, rnw}, {31'd0, !is_wr});
      if (is_wr) check(wd == ewd, "R6 write data", {16'd0, wd}, {16'd0, ewd});
      for (int i = 0; i < lat_fall; i++) begin
         @(negedge clk);
         check(mem_req, "R4 req held while wait high", {31'd0, mem_req}, 32'd1);
         check(mem_addr == a && mem_rnw == rnw && mem_wdata == wd,
               "R3 outputs stable", {20'd0, mem_addr}, {20'd0, a});
      end
      if (rnw) mem_rdata = mem_arr[a[3:0]];
      else begin
         check(mem_wdata == ewd, "R6 data at latch", {16'd0, mem_wdata}, {16'd0, ewd});
         mem_arr[a[3:0]] = mem_wdata;
      end
      mem_wait = 1'b0;
      n = 0;
      while (mem_req && n < 20) begin
         check(mem_addr == a && mem_wdata == wd, "R3 stable to wait fall",
               {20'd0, mem_addr}, {20'd0, a});
         @(negedge clk); n++;
      end
      check(!mem_req && n <= SS + 2, "R4 req drop latency", n, SS + 2);
      for (int i = 0; i < lat_rise; i++) begin
         @(negedge clk);
         check(!done, "R7 no done before wait rises", {31'd0, done}, 32'd0);
      end
      mem_wait = 1'b1;
      n = 0;
      while (!done && n < 10) begin @(negedge clk); n++; end
      check(done, "R7 done seen", {31'd0, done}, 32'd1);
      cmd_valid = 1'b0;
      dn = 0;
      for (int i = 0; i < 8; i++) begin
         if (done) dn++;
         @(negedge clk);
         check(!mem_req, "R8 no second request", {31'd0, mem_req}, 32'd0);
      end
      check(dn == 1, "R7 done one cycle", dn, 32'd1);
      check(cmd_ready, "R7 idle again", {31'd0, cmd_ready}, 32'd1);
   endtask

   task automatic run_xfer(input bit is_wr, input logic [AW-1:0] a,
                           input logic [DW-1:0] wd, input int lat_fall,
                           input int lat_rise, input bit keep);
      logic [DW-1:0] exp;
      exp = is_wr ? wd : mem_arr[a[3:0]];
      @(negedge clk);
      cmd_write = is_wr; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
      fork
         begin
            int n = 0;
            while (!mem_req && n < 200) begin @(negedge clk); n++; end
            if (keep) begin
               cmd_addr = ~a; cmd_wdata = ~wd; cmd_write = !is_wr;
            end else cmd_valid = 1'b0;
         end
         responder(is_wr, a, wd, lat_fall, lat_rise);
      join
      check(rdata == exp, is_wr ? "R6 rdata after write" : "R5 read capture",
            {16'd0, rdata}, {16'd0, exp});
   endtask

   task automatic t_reset();
      check(!mem_req && !done, "R1 reset req/done", {30'd0, mem_req, done}, 32'd0);
      check(rdata == '0, "R1 reset rdata", {16'd0, rdata}, 32'd0);
      check(mem_rnw, "R1 reset direction", {31'd0, mem_rnw}, 32'd1);
      rst_n = 1'b1;
      repeat (SS + 1) @(negedge clk);
      check(cmd_ready, "R1 ready after settle", {31'd0, cmd_ready}, 32'd1);
   endtask

   task automatic t_blocked();
      @(negedge clk);
      mem_wait = 1'b0;
      repeat (SS + 2) @(negedge clk);
      check(!cmd_ready, "R2 ready low while wait low", {31'd0, cmd_ready}, 32'd0);
      cmd_valid = 1'b1; cmd_write = 1'b0; cmd_addr = 12'h005;
      for (int i = 0; i < 12; i++) begin
         @(negedge clk);
         check(!mem_req, "R2 no request while wait low", {31'd0, mem_req}, 32'd0);
      end
      mem_wait = 1'b1;
      run_xfer(1'b0, 12'h005, '0, 2, 1, 1'b0);
   endtask

   initial begin
      for (int i = 0; i < 16; i++) mem_arr[i] = DW'(i * 16'h1111) ^ 16'h0a5a;
      repeat (3) @(negedge clk);
      t_reset();
      run_xfer(1'b0, 12'h003, '0, 1, 1, 1'b0);        // short read
      run_xfer(1'b1, 12'h007, 16'hbeef, 3, 2, 1'b0);  // write
      run_xfer(1'b0, 12'h007, '0, 5, 4, 1'b0);        // read back written word
      run_xfer(1'b1, 12'h00c, 16'h1234, 2, 3, 1'b1);  // command held, scrambled
      run_xfer(1'b0, 12'h00f, '0, 6, 1, 1'b1);        // held read
      t_blocked();
      finish_sim();
   end
endmodule